// File: doc/BRIEF.md
# Setup Packet Capture Buffer

This block sits between the receive side of a USB control endpoint and a CPU-side byte port. When the packet engine signals the start of a setup stage, the block clears its ready flag and writes the incoming bytes into an eight-entry store, starting from entry 0. When the eighth byte arrives marked as the last byte of the packet, the block raises a ready flag. The CPU then pulls the eight bytes out one per read strobe.

The USB side always wins. A CPU read strobe that arrives while a reception is running, or in the same cycle that a reception starts, is dropped. The read pointer does not move, the returned data is undefined, and a sticky abort flag is raised. The CPU clears that flag by pulsing a write-one-to-clear input.

The read pointer counts modulo 8 and is never realigned by a reception. Software must therefore always consume whole groups of eight bytes. A group that was abandoned partway leaves the next packet misaligned.

Top module: `setup_capture_buf`

## Requirements
- R1: After a synchronous active-low reset, `setup_rdy` is 0, `rd_abort` is 0, `cpu_rdata` is 0 and the read pointer is at entry 0.
- R2: A cycle with `rx_start` high ends any reception in progress and restarts writing at entry 0. From the next cycle `setup_rdy` is 0. A data byte offered in the same cycle as `rx_start` is not stored.
- R3: Bytes accepted during a reception (`rx_vld` high) are stored in arrival order in entries 0 to 7. An accepted CPU read returns the entry at the read pointer on `cpu_rdata` one cycle after the strobe, and then advances the pointer.
- R4: `setup_rdy` goes to 1 one cycle after the eighth byte of a reception is accepted with `rx_eop` high. A packet whose end mark comes on any other byte leaves `setup_rdy` at 0. `rx_eop` is only looked at together with `rx_vld`.
- R5: An accepted CPU read from entry 7 clears `setup_rdy` in the next cycle.
- R6: A `cpu_rd` strobe in a cycle where a reception is running, or where `rx_start` is high, is not accepted. The read pointer holds, and `rd_abort` is 1 from the next cycle. The data returned for such a strobe is undefined.
- R7: `rd_abort` stays at 1 until a cycle with `abort_clr` high, which clears it in the next cycle. If a new abort and a clear arrive in the same cycle, the abort wins.
- R8: The read pointer wraps from entry 7 to entry 0 and is reset only by R1. A reception does not realign it, so a partly read group shifts the byte order of the next packet.
- R9: Bytes beyond the eighth in one reception are discarded and do not overwrite stored entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_start | input | 1 | Start of a setup reception (one-cycle strobe) |
| rx_vld | input | 1 | A data byte is present on `rx_byte` |
| rx_byte | input | 8 | Received data byte |
| rx_eop | input | 1 | Byte on `rx_byte` is the last of the packet |
| cpu_rd | input | 1 | CPU read strobe, one byte per cycle |
| abort_clr | input | 1 | Write-one-to-clear for `rd_abort` |
| cpu_rdata | output | 8 | Byte returned by the last accepted read |
| setup_rdy | output | 1 | A complete 8-byte setup packet is waiting |
| rd_abort | output | 1 | Sticky flag: a CPU read was invalidated |

## Verification
Every result is registered once. `setup_rdy` responds one cycle after the edge that takes the final byte, the strobe for entry 7, or `rx_start`. `rd_abort` responds one cycle after a dropped strobe or a clear. `cpu_rdata` responds one cycle after an accepted strobe. The bench steps its behavioural model at each rising edge from the inputs held across that edge, and compares one time unit later, after the design's registers have settled. Read data is compared only in the cycle after an accepted read, so the undefined value returned for a dropped read is never checked.

// File: rtl/setup_buf_pkg.sv
// Package: setup_buf_pkg
// Shared types for the setup capture buffer. It holds the receive phase
// encoding used by the write controller and the default geometry.
package setup_buf_pkg;

    // Default geometry of the buffer
    localparam int unsigned SETUP_BYTES = 8;
    localparam int unsigned BYTE_W      = 8;

    // Receive phase of the write controller
    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,   // no reception running, CPU may read
        RX_FILL = 2'd1,   // accepting bytes into the store
        RX_FULL = 2'd2    // store full, waiting for end of packet
    } rx_phase_e;

endpackage

// File: rtl/setup_buf_wr_ctrl.sv
// Module: setup_buf_wr_ctrl
// Tracks a setup reception on the USB side. A start strobe restarts the
// write count at entry 0. Each valid byte is sent to the store until DEPTH
// bytes have been taken. A completion pulse is issued when byte DEPTH
// carries the end mark. Assumes rx_eop is meaningful only with rx_vld and
// that a byte offered in the start cycle belongs to no packet.
module setup_buf_wr_ctrl
    import setup_buf_pkg::*;
#(
    parameter int unsigned DEPTH = SETUP_BYTES
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_start,
    input  logic                       rx_vld,
    input  logic                       rx_eop,
    output logic                       wr_en,
    output logic [$clog2(DEPTH)-1:0]   wr_idx,
    output logic                       rx_busy,
    output logic                       fill_done
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    rx_phase_e        phase_q;
    logic [CNT_W-1:0] wcnt_q;

    // Decode the store write and the completion pulse from phase and count
    always_comb begin
        wr_en     = (phase_q == RX_FILL) && rx_vld && !rx_start;
        wr_idx    = wcnt_q[PTR_W-1:0];
        fill_done = wr_en && rx_eop && (wcnt_q == LAST_CNT);
        rx_busy   = (phase_q != RX_IDLE);
    end

    // Advance the receive phase and the write count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= RX_IDLE;
            wcnt_q  <= '0;
        end else if (rx_start) begin
            phase_q <= RX_FILL;
            wcnt_q  <= '0;
        end else begin
            case (phase_q)
                RX_FILL: begin
                    if (rx_vld) begin
                        wcnt_q <= wcnt_q + 1'b1;
                        if (rx_eop) begin
                            phase_q <= RX_IDLE;
                        end else if (wcnt_q == LAST_CNT) begin
                            phase_q <= RX_FULL;
                        end
                    end
                end
                RX_FULL: begin
                    if (rx_vld && rx_eop) begin
                        phase_q <= RX_IDLE;
                    end
                end
                default: phase_q <= RX_IDLE;
            endcase
        end
    end

    // R2: a start always opens a fresh reception at entry 0
    a_r2_restart_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start |=> (wcnt_q == '0) && rx_busy);

    // R9: the write count never runs past the store size
    a_r9_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt_q <= FULL_CNT);

    // R9: once full, no further write reaches the store
    a_r9_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == RX_FULL) |-> !wr_en);

endmodule

// File: rtl/setup_buf_store.sv
// Module: setup_buf_store
// DEPTH entries of DATA_W bits, one register slot per entry. Slots are
// written by index from the USB side and read through a mux by the CPU
// read pointer. Assumes at most one write per cycle.
module setup_buf_store #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(DEPTH)-1:0]   wr_idx,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [$clog2(DEPTH)-1:0]   rd_idx,
    output logic [DATA_W-1:0]          rd_data
);
    localparam int unsigned PTR_W = $clog2(DEPTH);

    logic [DEPTH*DATA_W-1:0] slots_flat;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [DATA_W-1:0] slot_q;

        // Capture the incoming byte when this slot is addressed
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (wr_en && (wr_idx == PTR_W'(i))) begin
                slot_q <= wr_data;
            end
        end

        assign slots_flat[i*DATA_W +: DATA_W] = slot_q;
    end

    // Select the entry under the read pointer
    always_comb begin
        rd_data = slots_flat[rd_idx*DATA_W +: DATA_W];
    end

    // R3: a written byte is visible at its index in the next cycle
    a_r3_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx == rd_idx)) |=> ($past(rd_idx) != rd_idx) || (rd_data == $past(wr_data)));

endmodule

// File: rtl/setup_buf_rd_port.sv
// Module: setup_buf_rd_port
// CPU-side read port. Accepts read strobes only while no reception runs,
// registers the byte under the pointer and advances the pointer modulo
// DEPTH. It also keeps the ready flag and the sticky abort flag. A strobe
// that collides with a reception or a start is dropped and marks an abort.
module setup_buf_rd_port #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cpu_rd,
    input  logic                       abort_clr,
    input  logic                       rx_start,
    input  logic                       rx_busy,
    input  logic                       fill_done,
    input  logic [DATA_W-1:0]          rd_byte,
    output logic [$clog2(DEPTH)-1:0]   rd_ptr,
    output logic [DATA_W-1:0]          cpu_rdata,
    output logic                       setup_rdy,
    output logic                       rd_abort
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic rd_ok;
    logic rd_kill;

    // Split a strobe into an accepted read or one dropped for the USB side
    always_comb begin
        rd_ok   = cpu_rd && !rx_busy && !rx_start;
        rd_kill = cpu_rd && (rx_busy || rx_start);
    end

    // Register the read byte and move the pointer on an accepted read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr    <= '0;
            cpu_rdata <= '0;
        end else if (rd_ok) begin
            cpu_rdata <= rd_byte;
            rd_ptr    <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
        end
    end

    // Ready flag: start clears, completion sets, reading the last entry clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_rdy <= 1'b0;
        end else if (rx_start) begin
            setup_rdy <= 1'b0;
        end else if (fill_done) begin
            setup_rdy <= 1'b1;
        end else if (rd_ok && (rd_ptr == LAST_PTR)) begin
            setup_rdy <= 1'b0;
        end
    end

    // Sticky abort flag: a dropped read sets it and beats a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_abort <= 1'b0;
        end else if (rd_kill) begin
            rd_abort <= 1'b1;
        end else if (abort_clr) begin
            rd_abort <= 1'b0;
        end
    end

    // R5: reading the last entry leaves the ready flag low
    a_r5_rdy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !rx_busy && !rx_start && (rd_ptr == LAST_PTR)) |=> !setup_rdy);

    // R6: a dropped strobe leaves the pointer where it was
    a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && (rx_busy || rx_start)) |=> $stable(rd_ptr));

    // R6: a dropped strobe is always flagged
    a_r6_abort_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && (rx_busy || rx_start)) |=> rd_abort);

    // R7: the abort flag only falls after a clear request
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_abort) |-> $past(abort_clr));

endmodule

// File: rtl/setup_capture_buf.sv
// Module: setup_capture_buf
// Top of the setup packet capture buffer. It joins the USB-side write
// controller, the byte store and the CPU-side read port. The USB side has
// priority: a CPU strobe during a reception is dropped and flagged. Assumes
// the start strobe, valid bytes and read strobes are synchronous to clk.
module setup_capture_buf
    import setup_buf_pkg::*;
#(
    parameter int unsigned DEPTH  = SETUP_BYTES,
    parameter int unsigned DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_start,
    input  logic              rx_vld,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_eop,
    input  logic              cpu_rd,
    input  logic              abort_clr,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              setup_rdy,
    output logic              rd_abort
);
    localparam int unsigned PTR_W = $clog2(DEPTH);

    logic             wr_en;
    logic [PTR_W-1:0] wr_idx;
    logic             rx_busy;
    logic             fill_done;
    logic [PTR_W-1:0] rd_ptr;
    logic [DATA_W-1:0] rd_byte;

    setup_buf_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_start  (rx_start),
        .rx_vld    (rx_vld),
        .rx_eop    (rx_eop),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .rx_busy   (rx_busy),
        .fill_done (fill_done)
    );

    setup_buf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (rx_byte),
        .rd_idx  (rd_ptr),
        .rd_data (rd_byte)
    );

    setup_buf_rd_port #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_rd    (cpu_rd),
        .abort_clr (abort_clr),
        .rx_start  (rx_start),
        .rx_busy   (rx_busy),
        .fill_done (fill_done),
        .rd_byte   (rd_byte),
        .rd_ptr    (rd_ptr),
        .cpu_rdata (cpu_rdata),
        .setup_rdy (setup_rdy),
        .rd_abort  (rd_abort)
    );

    // R4: ready only rises right after a byte carrying the end mark
    a_r4_rdy_on_eop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(setup_rdy) |-> $past(rx_vld && rx_eop && !rx_start));

    // R2: a start leaves the ready flag low in the next cycle
    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start |=> !setup_rdy);

endmodule

// File: tb/setup_capture_buf_test.sv
`timescale 1ns/1ps
module setup_capture_buf_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_start = 1'b0;
    logic       rx_vld = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_eop = 1'b0;
    logic       cpu_rd = 1'b0;
    logic       abort_clr = 1'b0;
    logic [7:0] cpu_rdata;
    logic       setup_rdy;
    logic       rd_abort;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Behavioural reference state
    int m_mem [8];
    int m_rptr = 0;
    int m_phase = 0;      // 0 idle, 1 filling, 2 full
    int m_cnt = 0;
    bit m_rdy = 0;
    bit m_abort = 0;
    bit m_def = 0;
    int m_data = 0;

    always #2 clk = ~clk;   // 250 MHz

    setup_capture_buf uut (
        .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_vld(rx_vld),
        .rx_byte(rx_byte), .rx_eop(rx_eop), .cpu_rd(cpu_rd),
        .abort_clr(abort_clr), .cpu_rdata(cpu_rdata),
        .setup_rdy(setup_rdy), .rd_abort(rd_abort)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Advance the reference model by one rising edge
    task automatic model_edge();
        bit kill;
        kill  = 1'b0;
        m_def = 1'b0;
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_mem[i] = 0;
            m_rptr = 0; m_phase = 0; m_cnt = 0; m_rdy = 0; m_abort = 0; m_data = 0;
            m_def = 1'b1;
        end else begin
            if (rx_start) begin
                kill = cpu_rd;
                m_phase = 1; m_cnt = 0; m_rdy = 0;
            end else begin
                if (cpu_rd) begin
                    if (m_phase != 0) kill = 1'b1;
                    else begin
                        m_data = m_mem[m_rptr];
                        m_def = 1'b1;
                        if (m_rptr == 7) m_rdy = 0;
                        m_rptr = (m_rptr + 1) % 8;
                    end
                end
                if (m_phase == 1 && rx_vld) begin
                    m_mem[m_cnt] = rx_byte;
                    m_cnt++;
                    if (rx_eop) begin
                        if (m_cnt == 8) m_rdy = 1;
                        m_phase = 0;
                    end else if (m_cnt == 8) m_phase = 2;
                end else if (m_phase == 2 && rx_vld && rx_eop) begin
                    m_phase = 0;
                end
            end
            if (kill) m_abort = 1;
            else if (abort_clr) m_abort = 0;
        end
    endtask

    // One clock: model at the edge, compare after the registers settle
    task automatic step();
        @(posedge clk);
        model_edge();
        #1;
        if (rst_n) begin
            check("R4", "setup_rdy", setup_rdy, m_rdy);
            check("R6", "rd_abort", rd_abort, m_abort);
            if (m_def) check("R3", "cpu_rdata", cpu_rdata, m_data);
        end
        rx_start = 0; rx_vld = 0; rx_eop = 0; cpu_rd = 0; abort_clr = 0;
    endtask

    task automatic start_rx();
        rx_start = 1; step();
    endtask

    task automatic send_byte(input logic [7:0] b, input bit last);
        rx_vld = 1; rx_byte = b; rx_eop = last; step();
    endtask

    task automatic send_packet(input logic [7:0] base, input int len, input bit gaps);
        start_rx();
        for (int i = 0; i < len; i++) begin
            send_byte(base + 8'(i), i == len - 1);
            if (gaps && (i % 3 == 1)) step();
        end
    endtask

    task automatic read_byte();
        cpu_rd = 1; step();
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1;
        #1;
        // R1: reset state
        check("R1", "setup_rdy after reset", setup_rdy, 0);
        check("R1", "rd_abort after reset", rd_abort, 0);
        check("R1", "cpu_rdata after reset", cpu_rdata, 0);

        // R3, R4, R5: clean packet, full read
        send_packet(8'h01, 8, 0);
        check("R4", "ready after eighth byte", setup_rdy, 1);
        for (int i = 0; i < 7; i++) read_byte();
        check("R5", "ready before last read", setup_rdy, 1);
        read_byte();
        check("R3", "last byte", cpu_rdata, 8'h08);
        check("R5", "ready after last read", setup_rdy, 0);

        // R4: packet with gaps between bytes
        send_packet(8'hA0, 8, 1);
        check("R4", "ready with gaps", setup_rdy, 1);
        read_byte();
        check("R3", "first gapped byte", cpu_rdata, 8'hA0);
        for (int i = 0; i < 7; i++) read_byte();

        // R4: short packet never becomes ready
        send_packet(8'h50, 5, 0);
        check("R4", "short packet not ready", setup_rdy, 0);

        // R9: long packet keeps only its first eight bytes
        send_packet(8'hC0, 10, 0);
        check("R4", "long packet not ready", setup_rdy, 0);
        read_byte();
        check("R9", "entry 0 of long packet", cpu_rdata, 8'hC0);
        for (int i = 0; i < 7; i++) read_byte();
        check("R9", "entry 7 of long packet", cpu_rdata, 8'hC7);

        // R2: byte offered with the start is not stored
        rx_start = 1; rx_vld = 1; rx_byte = 8'hEE; step();
        check("R2", "ready cleared by start", setup_rdy, 0);
        for (int i = 0; i < 8; i++) send_byte(8'h30 + 8'(i), i == 7);
        read_byte();
        check("R2", "first byte after start", cpu_rdata, 8'h30);
        for (int i = 0; i < 7; i++) read_byte();

        // R6, R8: partial read, then a start collides with a strobe
        send_packet(8'h10, 8, 0);
        read_byte(); read_byte(); read_byte();
        rx_start = 1; cpu_rd = 1; step();
        check("R6", "abort on strobe at start", rd_abort, 1);
        check("R2", "ready cleared by new start", setup_rdy, 0);
        send_byte(8'h20, 0);
        cpu_rd = 1; send_byte(8'h21, 0);
        for (int i = 2; i < 8; i++) send_byte(8'h20 + 8'(i), i == 7);
        check("R4", "ready after aborted read", setup_rdy, 1);
        read_byte();
        check("R8", "pointer not realigned", cpu_rdata, 8'h23);
        for (int i = 0; i < 4; i++) read_byte();
        check("R5", "ready cleared at entry 7", setup_rdy, 0);
        read_byte();
        check("R8", "pointer wraps to entry 0", cpu_rdata, 8'h20);
        read_byte(); read_byte();

        // R7: sticky flag, clear, and set beating clear
        step();
        check("R7", "abort still sticky", rd_abort, 1);
        abort_clr = 1; step();
        check("R7", "abort cleared", rd_abort, 0);
        rx_start = 1; cpu_rd = 1; abort_clr = 1; step();
        check("R7", "set wins over clear", rd_abort, 1);
        for (int i = 0; i < 8; i++) send_byte(8'h40 + 8'(i), i == 7);
        abort_clr = 1; step();
        check("R7", "abort cleared again", rd_abort, 0);
        step();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule